// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block drives the row and column strobes of an asynchronous DRAM while the memory is idle from the access side. After reset it holds every strobe inactive for the power-up settling time. It then runs a fixed burst of initialisation RAS pulses, and only after that raises `ready_o`. From then on an interval timer adds one owed refresh every refresh period. The period is chosen so that a 512-row array is fully covered inside its 8 ms retention window, which works out to about 15.6 µs per row.

Owed refreshes are offered to the access controller on a request/grant handshake. A request stays raised until it is granted. Each grant produces one refresh pulse with a programmable RAS active time and precharge time, and ends with a one-cycle done strobe. Two refresh styles are available. In CAS-before-RAS style, both CAS strobes drop one cycle ahead of RAS and the memory's own row counter is used. In RAS-only style, a local 9-bit row counter is driven onto the address bus and both CAS strobes stay high. The style is fixed by a static input that is captured once after reset. Because any ordinary RAS cycle also refreshes its row, the access controller may postpone grants, and the owed count absorbs that delay up to a limit.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `cas_lo_n_o` and `cas_hi_n_o` are 1, and `ready_o`, `ref_req_o`, `ref_done_o` and `addr_oe_o` are 0, and `pend_cnt_o` is 0.
- R2: After reset is released, all strobes stay high for at least PWRUP_US × CLK_MHZ clock cycles before the first fall of `ras_n_o`.
- R3: The first INIT_PULSES RAS pulses after power-up keep both CAS strobes high and `addr_oe_o` at 0. `ready_o` rises only after the last of them has finished its precharge, and then stays at 1. `ref_req_o` is never 1 while `ready_o` is 0.
- R4: Once ready, one refresh is added to `pend_cnt_o` every REF_INTERVAL_NS × CLK_MHZ / 1000 cycles. `ref_req_o` is 1 whenever the count is non-zero and no pulse is in progress.
- R5: `ref_req_o` stays at 1 until `ref_gnt_i` is seen. `pend_cnt_o` saturates at MAX_OWED, and each accepted grant removes one refresh from the count.
- R6: Every pulse holds `ras_n_o` low for exactly T_RAS_CYC cycles and then high for T_RP_CYC cycles. A refresh pulse is followed by `ref_done_o` at 1 for one cycle, in the cycle after the precharge. Initialisation pulses produce no done.
- R7: In CAS-before-RAS style, both CAS strobes are 0 in the cycle before `ras_n_o` falls and for as long as it stays low, and `addr_oe_o` stays 0.
- R8: In RAS-only style, `addr_oe_o` is 1 and `row_addr_o` carries the row while `ras_n_o` is low, with both CAS strobes at 1.
- R9: The RAS-only row starts at 0 after reset. It advances by one, modulo 512, after every RAS-only refresh, and it does not move for a CAS-before-RAS refresh.
- R10: `ras_only_i` is captured on the first clock after reset is released, with 1 meaning RAS-only and 0 meaning CAS-before-RAS. Later changes on it have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh style select: 1 RAS-only, 0 CAS-before-RAS |
| ref_gnt_i | input | 1 | Grant from the access controller |
| ref_req_o | output | 1 | Refresh request to the access controller |
| ref_done_o | output | 1 | One-cycle strobe at the end of a refresh |
| ready_o | output | 1 | Power-up and initialisation complete |
| pend_cnt_o | output | $clog2(MAX_OWED+1) | Number of owed refreshes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_lo_n_o | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n_o | output | 1 | Upper-byte column strobe, active low |
| addr_oe_o | output | 1 | Drive row address onto the memory bus |
| row_addr_o | output | ROW_W | Row address for RAS-only refresh |

## Verification
The properties watch the handshake and strobe rules on every cycle. They check that a request never appears before ready and is held until granted, that the owed count stays within its limit, and that CAS leads RAS in CAS-before-RAS pulses. They also check that the CAS strobes stay high whenever the row address is driven, that the row steps by exactly one at each RAS-only done, and that the captured style never changes. Only the scenarios can show the length of the power-up wait and the count of initialisation pulses. The same holds for the exact active and precharge widths, the sequence of rows across the 512 wrap, saturation after withheld grants, and the fact that toggling the style input mid-run changes nothing.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_CSU  = 3'd1,
    ST_ACT  = 3'd2,
    ST_PRE  = 3'd3,
    ST_IDLE = 3'd4
  } seq_st_e;
endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int PERIOD = 781,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drs_owed.sv
module drs_owed #(
  parameter int MAX_OWED = 4,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [OW-1:0] cnt_o
);
  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && (cnt_q != OW'(MAX_OWED))) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && (cnt_q != '0))            cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1; // natural wrap at 2**ROW_W
  end

  assign row_o = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int CLK_MHZ         = 50,
  parameter int PWRUP_US        = 200,
  parameter int REF_INTERVAL_NS = 15625,
  parameter int INIT_PULSES     = 8,
  parameter int T_RAS_CYC       = 3,
  parameter int T_RP_CYC        = 2,
  parameter int MAX_OWED        = 4,
  parameter int ROW_W           = 9,
  localparam int OWED_W         = $clog2(MAX_OWED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_only_i,
  input  logic              ref_gnt_i,
  output logic              ref_req_o,
  output logic              ref_done_o,
  output logic              ready_o,
  output logic [OWED_W-1:0] pend_cnt_o,
  output logic              ras_n_o,
  output logic              cas_lo_n_o,
  output logic              cas_hi_n_o,
  output logic              addr_oe_o,
  output logic [ROW_W-1:0]  row_addr_o
);
  localparam int PWR_CYC = PWRUP_US * CLK_MHZ;
  localparam int REFI_CYC = (REF_INTERVAL_NS * CLK_MHZ) / 1000;
  localparam int PULSE_MAX = (T_RAS_CYC > T_RP_CYC) ? T_RAS_CYC : T_RP_CYC;
  localparam int TMR_MAX = (PWR_CYC > PULSE_MAX) ? PWR_CYC : PULSE_MAX;
  localparam int TMR_W = $clog2(TMR_MAX + 1);
  localparam int INIT_W = (INIT_PULSES > 1) ? $clog2(INIT_PULSES) : 1;

  seq_st_e           st_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [INIT_W-1:0] ninit_q;
  logic              init_q;
  logic              ready_q;
  logic              done_q;
  logic              mode_ras_only_q;
  logic              locked_q;
  logic              tick;
  logic              accept;
  logic              pre_end;
  logic              row_step;
  logic              cas_act;

  // Style select is captured once, on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_ras_only_q <= 1'b0;
      locked_q        <= 1'b0;
    end else if (!locked_q) begin
      mode_ras_only_q <= ras_only_i;
      locked_q        <= 1'b1;
    end
  end

  assign ref_req_o = ready_q && (st_q == ST_IDLE) && (pend_cnt_o != '0);
  assign accept    = ref_req_o && ref_gnt_i;
  assign pre_end   = (st_q == ST_PRE) && (tmr_q == TMR_W'(T_RP_CYC - 1));
  assign row_step  = pre_end && !init_q && mode_ras_only_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PWR;
      tmr_q   <= '0;
      ninit_q <= '0;
      init_q  <= 1'b1;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmr_q  <= tmr_q + 1'b1;
      unique case (st_q)
        ST_PWR: begin
          if (tmr_q == TMR_W'(PWR_CYC)) begin
            st_q  <= ST_ACT;
            tmr_q <= '0;
          end
        end
        ST_CSU: begin
          st_q  <= ST_ACT;
          tmr_q <= '0;
        end
        ST_ACT: begin
          if (tmr_q == TMR_W'(T_RAS_CYC - 1)) begin
            st_q  <= ST_PRE;
            tmr_q <= '0;
          end
        end
        ST_PRE: begin
          if (pre_end) begin
            tmr_q <= '0;
            if (init_q) begin
              if (ninit_q == INIT_W'(INIT_PULSES - 1)) begin
                st_q    <= ST_IDLE;
                init_q  <= 1'b0;
                ready_q <= 1'b1;
              end else begin
                ninit_q <= ninit_q + 1'b1;
                st_q    <= ST_ACT;
              end
            end else begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        ST_IDLE: begin
          tmr_q <= '0;
          if (accept) st_q <= mode_ras_only_q ? ST_ACT : ST_CSU;
        end
        default: st_q <= ST_PWR;
      endcase
    end
  end

  drs_interval #(.PERIOD(REFI_CYC)) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ready_q),
    .tick_o (tick)
  );

  drs_owed #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (accept),
    .cnt_o  (pend_cnt_o)
  );

  drs_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (row_step),
    .row_o  (row_addr_o)
  );

  // CAS leads RAS only for CAS-before-RAS refresh pulses
  assign cas_act    = !init_q && !mode_ras_only_q && ((st_q == ST_CSU) || (st_q == ST_ACT));
  assign ras_n_o    = (st_q != ST_ACT);
  assign cas_lo_n_o = !cas_act;
  assign cas_hi_n_o = !cas_act;
  assign addr_oe_o  = (st_q == ST_ACT) && !init_q && mode_ras_only_q;
  assign ref_done_o = done_q;
  assign ready_o    = ready_q;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int ROW_W    = 9,
  parameter int OWED_W   = 3,
  parameter int MAX_OWED = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_gnt_i,
  input logic              ref_req_o,
  input logic              ref_done_o,
  input logic              ready_o,
  input logic [OWED_W-1:0] pend_cnt_o,
  input logic              ras_n_o,
  input logic              cas_lo_n_o,
  input logic              cas_hi_n_o,
  input logic              addr_oe_o,
  input logic [ROW_W-1:0]  row_addr_o,
  input logic              mode_q,
  input logic              locked_q
);
  a_r3_no_req_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> ready_o);

  a_r3_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i) |=> ref_req_o);

  a_r5_owed_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt_o <= OWED_W'(MAX_OWED));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);

  a_r6_done_after_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |-> (ras_n_o && $past(ras_n_o)));

  a_r7_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_lo_n_o) |-> ($past(!cas_lo_n_o) && $past(!cas_hi_n_o) && !addr_oe_o));

  a_r8_rasonly_cas_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o |-> (!ras_n_o && cas_lo_n_o && cas_hi_n_o));

  a_r9_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_done_o && mode_q) |-> (row_addr_o == ROW_W'($past(row_addr_o) + 1'b1)));

  a_r9_row_hold_cbr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_done_o && !mode_q) |-> $stable(row_addr_o));

  a_r10_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(mode_q));
endmodule

bind dram_refresh_seq drs_checker #(
  .ROW_W(ROW_W), .OWED_W(OWED_W), .MAX_OWED(MAX_OWED)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_gnt_i  (ref_gnt_i),
  .ref_req_o  (ref_req_o),
  .ref_done_o (ref_done_o),
  .ready_o    (ready_o),
  .pend_cnt_o (pend_cnt_o),
  .ras_n_o    (ras_n_o),
  .cas_lo_n_o (cas_lo_n_o),
  .cas_hi_n_o (cas_hi_n_o),
  .addr_oe_o  (addr_oe_o),
  .row_addr_o (row_addr_o),
  .mode_q     (mode_ras_only_q),
  .locked_q   (locked_q)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int PWR_CYC = 200 * 50;
  localparam int REFI    = 50;
  localparam int T_RAS   = 3;
  localparam int T_RP    = 2;
  localparam int NINIT   = 8;
  localparam int MAXO    = 4;
  localparam int K_INIT  = 0;
  localparam int K_CBR   = 1;
  localparam int K_RAS   = 2;

  typedef struct { int kind; int row; } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ras_only_i = 1'b1;
  logic       ref_gnt_i;
  logic       ref_req_o, ref_done_o, ready_o;
  logic [2:0] pend_cnt_o;
  logic       ras_n_o, cas_lo_n_o, cas_hi_n_o, addr_oe_o;
  logic [8:0] row_addr_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   hold = 1'b1;
  bit   mode_ras = 1'b1;
  int   exp_row = 0;
  int   ras_cnt = 0;
  int   cbr_cnt = 0;
  bit   wrap_seen = 1'b0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  dram_refresh_seq #(.REF_INTERVAL_NS(1000)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_only_i (ras_only_i),
    .ref_gnt_i  (ref_gnt_i),
    .ref_req_o  (ref_req_o),
    .ref_done_o (ref_done_o),
    .ready_o    (ready_o),
    .pend_cnt_o (pend_cnt_o),
    .ras_n_o    (ras_n_o),
    .cas_lo_n_o (cas_lo_n_o),
    .cas_hi_n_o (cas_hi_n_o),
    .addr_oe_o  (addr_oe_o),
    .row_addr_o (row_addr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push_init();
    for (int i = 0; i < NINIT; i++) exp_q.push_back('{K_INIT, 0});
  endtask

  task automatic check_reset_state();
    @(negedge clk_i);
    check(ras_n_o && cas_lo_n_o && cas_hi_n_o, "R1 strobes", {ras_n_o, cas_lo_n_o, cas_hi_n_o}, 7);
    check(!ready_o && !ref_req_o && !ref_done_o && !addr_oe_o, "R1 flags",
          {ready_o, ref_req_o, ref_done_o, addr_oe_o}, 0);
    check(pend_cnt_o == 0, "R1 pend", pend_cnt_o, 0);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < PWR_CYC + 400 && !ready_o; i++) @(negedge clk_i);
    check(ready_o, "R3 ready", ready_o, 1);
    check(exp_q.size() == 0, "R3 init count", exp_q.size(), 0);
  endtask

  // Driver: acts as the access controller and records the expected pulse
  initial begin
    ref_gnt_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && !hold && ref_req_o && !ref_gnt_i) begin
        if (mode_ras) begin
          exp_q.push_back('{K_RAS, exp_row});
          exp_row = (exp_row + 1) % 512;
        end else begin
          exp_q.push_back('{K_CBR, 0});
        end
        ref_gnt_i = 1'b1;
      end else begin
        ref_gnt_i = 1'b0;
      end
    end
  end

  // Monitor: measures each RAS pulse and compares against the scoreboard
  initial begin
    int   lo_len = 0;
    int   hi_cnt = 0;
    bit   saw_cas = 0, saw_oe = 0, pre_cas = 0, prev_cas = 0, prev_ras = 1;
    int   row_cap = 0;
    int   last_kind = K_INIT;
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        prev_ras = 1; prev_cas = 0; lo_len = 0; hi_cnt = 0;
      end else begin
        if (!ras_n_o) begin
          if (prev_ras) begin
            lo_len = 0; saw_cas = 0; saw_oe = 0; pre_cas = prev_cas; row_cap = row_addr_o;
          end
          lo_len++;
          if (!cas_lo_n_o && !cas_hi_n_o) saw_cas = 1;
          if (addr_oe_o) saw_oe = 1;
        end else begin
          if (!prev_ras) begin
            hi_cnt = 0;
            if (exp_q.size() == 0) begin
              check(0, "R6 unexpected pulse", lo_len, 0);
            end else begin
              int obs;
              e = exp_q.pop_front();
              obs = saw_oe ? K_RAS : (saw_cas ? K_CBR : K_INIT);
              last_kind = obs;
              check(obs == e.kind, "R10 pulse style", obs, e.kind);
              check(lo_len == T_RAS, "R6 active width", lo_len, T_RAS);
              if (e.kind == K_INIT) begin
                check(!ready_o, "R3 not ready during init", ready_o, 0);
              end else if (e.kind == K_CBR) begin
                check(pre_cas, "R7 CAS before RAS", pre_cas, 1);
                cbr_cnt++;
              end else begin
                check(row_cap == e.row, "R8 R9 row", row_cap, e.row);
                if (e.row == 0 && ras_cnt > 0) wrap_seen = 1'b1;
                ras_cnt++;
              end
            end
          end
          hi_cnt++;
        end
        if (ref_done_o) begin
          check(hi_cnt == T_RP + 1, "R6 done timing", hi_cnt, T_RP + 1);
          check(last_kind != K_INIT, "R6 no done for init", last_kind, K_RAS);
        end
        prev_ras = ras_n_o;
        prev_cas = !cas_lo_n_o && !cas_hi_n_o;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int hi_run;
    // Phase 1: RAS-only style
    ras_only_i = 1'b1; mode_ras = 1'b1; hold = 1'b1;
    repeat (3) @(negedge clk_i);
    check_reset_state();
    push_init();
    rst_ni = 1'b1;
    hi_run = 0;
    while (ras_n_o && hi_run < PWR_CYC + 100) begin
      @(negedge clk_i);
      if (ras_n_o) hi_run++;
      check(!(ras_n_o && (!cas_lo_n_o || !cas_hi_n_o)), "R2 CAS quiet", cas_lo_n_o, 1);
    end
    check(hi_run >= PWR_CYC && hi_run <= PWR_CYC + 2, "R2 power-up wait", hi_run, PWR_CYC);
    wait_ready();

    // Owed accumulation with grants withheld
    repeat (3 * REFI + 10) @(negedge clk_i);
    check(pend_cnt_o == 3, "R4 owed count", pend_cnt_o, 3);
    check(ref_req_o, "R4 request raised", ref_req_o, 1);
    repeat (3 * REFI) @(negedge clk_i);
    check(pend_cnt_o == MAXO, "R5 saturation", pend_cnt_o, MAXO);
    check(ref_req_o, "R5 request held", ref_req_o, 1);
    hold = 1'b0;
    repeat (REFI) @(negedge clk_i);
    check(ras_cnt >= MAXO, "R5 backlog drained", ras_cnt, MAXO);

    // Style input change must be ignored
    ras_only_i = 1'b0;
    repeat (520 * REFI) @(negedge clk_i);
    hold = 1'b1;
    repeat (20) @(negedge clk_i);
    check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
    check(wrap_seen, "R9 row wrap", wrap_seen, 1);

    // Phase 2: CAS-before-RAS style
    rst_ni = 1'b0; ras_only_i = 1'b0; mode_ras = 1'b0; exp_row = 0;
    exp_q.delete();
    check_reset_state();
    push_init();
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    ras_only_i = 1'b1;
    wait_ready();
    hold = 1'b0;
    repeat (5 * REFI + 10) @(negedge clk_i);
    hold = 1'b1;
    repeat (20) @(negedge clk_i);
    check(cbr_cnt >= 4, "R7 CBR refreshes", cbr_cnt, 5);
    check(exp_q.size() == 0, "R10 CBR scoreboard", exp_q.size(), 0);
    check(row_addr_o == 0, "R9 row frozen in CBR", row_addr_o, 0);
    summary();
  end
endmodule